// File: doc/BRIEF.md
# Four-Digit Multiplexed Display Scanner

This block drives four seven-segment digits that share one set of segment lines. Each digit has its own anode enable. The block takes four 4-bit BCD values and lights one digit at a time. Every digit gets the same dwell time, and the scan is fast enough that all four look steadily lit.

A free-running divider makes a one-cycle tick every `TICK_DIV` clocks. At 100 MHz the default of 100000 gives a tick every 1 ms. On each tick a four-state selector moves to the next digit. The selector does two jobs:
- It picks that digit's BCD value for one shared segment decoder.
- It pulls that digit's anode low.

Each digit is therefore lit for one tick period out of every four.

Top module: `disp_scan`

## Requirements
- R1: While `rst_n` is low and right after it rises, the selector is at digit 0. `an_n` is 4'b1110 and `seg_n` shows `dig0`.
- R2: The selector holds each position for exactly `TICK_DIV` clock cycles. The first advance happens on the `TICK_DIV`-th rising edge after reset is released.
- R3: The selector visits digits in the order 0, 1, 2, 3 and then back to 0. The matching `an_n` values are 4'b1110, 4'b1101, 4'b1011 and 4'b0111, so bit i belongs to digit i.
- R4: Out of reset, exactly one bit of `an_n` is low in every cycle.
- R5: `seg_n` shows the decoded value of the BCD input of the currently selected digit. It follows changes to that input in the same cycle.
- R6: `seg_n` is active low, with bit 0 = a through bit 6 = g. For BCD 0 to 9, the active-high patterns (g..a) are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R7: BCD codes 10 to 15 blank the digit, so `seg_n` is 7'h7F.
- R8: Changes on the BCD inputs of digits that are not selected leave `seg_n` unchanged.
- R9: Asserting `rst_n` low in the middle of a scan returns the selector to digit 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dig0 | input | 4 | BCD value of the least significant digit |
| dig1 | input | 4 | BCD value of digit 1 |
| dig2 | input | 4 | BCD value of digit 2 |
| dig3 | input | 4 | BCD value of the most significant digit |
| seg_n | output | 7 | Segment lines, active low, bit 0 = a |
| an_n | output | 4 | Anode enables, active low, bit i = digit i |

## Verification
A selector that skips, stalls or jumps shows up on `an_n` at the first tick boundary. A divider with the wrong period moves that boundary by at least one cycle, so the bench checks the anode value in every cycle across two full scans. A wrong mux or decoder entry is caught by walking all sixteen codes through the selected digit. Toggling the unselected inputs catches a mux that leaks another digit onto `seg_n`.

// File: rtl/disp_scan.sv
module disp_scan #(
  parameter int TICK_DIV = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] dig0,
  input  logic [3:0] dig1,
  input  logic [3:0] dig2,
  input  logic [3:0] dig3,
  output logic [6:0] seg_n,
  output logic [3:0] an_n
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  typedef enum logic [1:0] {S_D0 = 2'b00, S_D1 = 2'b01, S_D2 = 2'b10, S_D3 = 2'b11} sel_t;

  logic [CW-1:0] cnt;
  logic          tick;
  sel_t          sel;
  logic [3:0]    bcd;
  logic [6:0]    seg;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel <= S_D0;
    else if (tick)
      case (sel)
        S_D0:    sel <= S_D1;
        S_D1:    sel <= S_D2;
        S_D2:    sel <= S_D3;
        default: sel <= S_D0;
      endcase

  always_comb
    case (sel)
      S_D0:    bcd = dig0;
      S_D1:    bcd = dig1;
      S_D2:    bcd = dig2;
      default: bcd = dig3;
    endcase

  always_comb
    case (bcd)
      4'd0:    seg = 7'h3F;
      4'd1:    seg = 7'h06;
      4'd2:    seg = 7'h5B;
      4'd3:    seg = 7'h4F;
      4'd4:    seg = 7'h66;
      4'd5:    seg = 7'h6D;
      4'd6:    seg = 7'h7D;
      4'd7:    seg = 7'h07;
      4'd8:    seg = 7'h7F;
      4'd9:    seg = 7'h6F;
      default: seg = 7'h00;
    endcase

  assign seg_n = ~seg;
  assign an_n  = ~(4'b0001 << sel);

  // R4: one anode enabled at a time
  a_r4_one_anode: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~an_n) == 1);

  // R2: selector holds between ticks
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sel));

  // R3: selector steps by one on a tick, wrapping 3 to 0
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> sel == sel_t'($past(sel) + 2'd1));

  // R2: divider stays in range
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R7: codes above nine blank the digit
  a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd > 4'd9) |-> seg_n == 7'h7F);
endmodule

// File: tb/sim_disp_scan.sv
module sim_disp_scan;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] dig0 = 4'd0, dig1 = 4'd0, dig2 = 4'd0, dig3 = 4'd0;
  logic [6:0] seg_n;
  logic [3:0] an_n;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  disp_scan #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .dig0(dig0), .dig1(dig1), .dig2(dig2), .dig3(dig3),
    .seg_n(seg_n), .an_n(an_n));

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    logic [6:0] p;
    case (v)
      4'd0: p = 7'h3F; 4'd1: p = 7'h06; 4'd2: p = 7'h5B; 4'd3: p = 7'h4F;
      4'd4: p = 7'h66; 4'd5: p = 7'h6D; 4'd6: p = 7'h7D; 4'd7: p = 7'h07;
      4'd8: p = 7'h7F; 4'd9: p = 7'h6F; default: p = 7'h00;
    endcase
    return ~p;
  endfunction

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R1 an_n in reset", {3'b0, an_n}, 7'b1110);
    chk("R1 seg_n in reset", seg_n, exp_seg(dig0));
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    dig0 = 4'd3; dig1 = 4'd1; dig2 = 4'd4; dig3 = 4'd1;
    do_reset();
    chk("R1 an_n after release", {3'b0, an_n}, 7'b1110);
  endtask

  task automatic t_scan();
    logic [3:0] d [4];
    d[0] = 4'd2; d[1] = 4'd7; d[2] = 4'd5; d[3] = 4'd9;
    dig0 = d[0]; dig1 = d[1]; dig2 = d[2]; dig3 = d[3];
    do_reset();
    for (int r = 0; r < 2; r++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < DIV; k++) begin
          chk("R2/R3 an_n dwell and order", {3'b0, an_n}, {3'b0, ~(4'b0001 << p)});
          chk("R4 one anode low", 7'($countones(~an_n)), 7'd1);
          chk("R5 seg_n of selected digit", seg_n, exp_seg(d[p]));
          @(negedge clk);
        end
  endtask

  task automatic t_decode();
    do_reset();
    for (int v = 0; v < 16; v++) begin
      dig0 = 4'(v);
      #0.5;
      if (v < 10) chk("R6 decode 0-9", seg_n, exp_seg(4'(v)));
      else        chk("R7 blank 10-15", seg_n, 7'h7F);
    end
  endtask

  task automatic t_unselected();
    dig0 = 4'd6;
    do_reset();
    for (int v = 0; v < 16; v++) begin
      dig1 = 4'(v); dig2 = 4'(15 - v); dig3 = 4'(v ^ 5);
      #0.5;
      chk("R8 unselected inputs ignored", seg_n, exp_seg(4'd6));
    end
  endtask

  task automatic t_midreset();
    do_reset();
    repeat (2 * DIV + 3) @(negedge clk);
    chk("R9 mid-scan position", {3'b0, an_n}, 7'b1011);
    rst_n = 1'b0;
    #0.5;
    chk("R9 reset returns to digit 0", {3'b0, an_n}, 7'b1110);
    @(negedge clk) rst_n = 1'b1;
    repeat (DIV - 1) @(negedge clk);
    chk("R9 full dwell after reset", {3'b0, an_n}, 7'b1110);
    @(negedge clk);
    chk("R9 advance after reset", {3'b0, an_n}, 7'b1101);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_scan();
        t_decode();
        t_unselected();
        t_midreset();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule